// File: doc/BRIEF.md
# Sprite Plane Address Register Shadowing

This block holds the address programming for one overlay sprite plane: surface start address, line stride and panning offset. Software writes through a simple register write port, and the values land in pending copies. The display fetch engine sees only the live copies. Those are refreshed from the pending copies at a vertical-blank pulse, and only once a write to the start register has armed the refresh. A stride write alone therefore never moves the live stride. Software writes the stride first and then the start address, and both take effect together at the next frame boundary.

The block also produces the address of each displayed line's first pixel. At every vertical blank this address reloads to start plus offset. Each horizontal line-start strobe then moves it by one stride. In normal orientation it moves forward. With 180-degree rotation it moves backward, since the offset then names the last pixel of the last unrotated line.

The stride is cleaned as it is written. Bits below 64-byte granularity are always dropped. In tiled memory the stride is further forced to 256-byte granularity, which raises a sticky error flag if any bit had to be cleared. It is also capped at 16 KiB.

Top module: `sprite_addr_shadow`

## Requirements
- R1: After reset the pending and live start, stride and offset, the line address, the armed flag and the error flag are all zero.
- R2: Read select 0 returns the pending start, 1 the pending stride and 2 the pending offset. The stride always has bits 5:0 zero, so in linear mode (tiled_mode=0) it is a multiple of 64 and otherwise equals the written value.
- R3: In tiled mode (tiled_mode=1) a stride write also clears bits 7:6. If either of those bits was set in the written data, stride_err is set and stays set until any write with write select 3.
- R4: In tiled mode a stride whose cleaned value exceeds 16384 is stored as 16384. No cap applies in linear mode.
- R5: Writes to stride (select 1) or offset (select 2) alone leave the live values unchanged, even across a vertical blank.
- R6: A write to start (select 0) sets update_armed one cycle later. A vertical blank seen while armed copies all three pending values to the live outputs and clears update_armed.
- R7: A start write in the same cycle as a vertical blank is not transferred by that blank. update_armed is set after it, and the next vertical blank transfers the new value.
- R8: At every vertical blank, line_addr loads live start plus live offset, using the values the live registers hold after that same blank.
- R9: With rot180=0, each line_strobe without vblank adds live_stride to line_addr.
- R10: With rot180=1, each line_strobe without vblank subtracts live_stride from line_addr.
- R11: Read select 3 returns a status word with update_armed in bit 0, stride_err in bit 1 and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start, 1 stride, 2 offset, 3 status (clears error) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target: 0 start, 1 stride, 2 offset, 3 status |
| rd_data | output | 32 | Read data for rd_sel |
| tiled_mode | input | 1 | 1 selects tiled memory stride rules |
| rot180 | input | 1 | 1 walks lines backward |
| vblank | input | 1 | Vertical blank pulse |
| line_strobe | input | 1 | Horizontal line-start pulse |
| live_start | output | 32 | Live surface start address |
| live_stride | output | 32 | Live stride in bytes |
| live_offset | output | 32 | Live panning offset |
| line_addr | output | 32 | Address of current line's first pixel |
| update_armed | output | 1 | Pending copies will transfer at the next vertical blank |
| stride_err | output | 1 | Sticky tiled-stride alignment error |

## Verification
On every cycle the assertions check that live values hold still without an armed blank, that arming and disarming follow start writes and blanks, that live stride keeps 64-byte granularity, that tiled stride writes respect the cap and the 256-byte granularity, and that line_addr reloads and steps by exactly one stride in the chosen direction. Only the bench scenarios can show that the transferred values are the ones software wrote. They also show the stride cleaning for specific data patterns, the error flag's set and clear, and the one-frame delay of a start write that coincides with a blank.

// File: rtl/sprite_shadow_pkg.sv
package sprite_shadow_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_STRIDE = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sprite_stride_filter.sv
module sprite_stride_filter #(
  parameter int unsigned AW        = 32,
  parameter int unsigned LIN_LSB   = 6,
  parameter int unsigned TILE_LSB  = 8,
  parameter int unsigned TILE_MAX  = 16384
) (
  input  logic [AW-1:0] raw,
  input  logic          tiled,
  output logic [AW-1:0] clean,
  output logic          misalign
);
  localparam logic [AW-1:0] LIN_MASK  = ~((AW'(1) << LIN_LSB) - AW'(1));
  localparam logic [AW-1:0] TILE_MASK = ~((AW'(1) << TILE_LSB) - AW'(1));
  localparam logic [AW-1:0] CAP       = AW'(TILE_MAX);

  logic [AW-1:0] lin_val;
  logic [AW-1:0] tile_val;

  always_comb begin
    lin_val  = raw & LIN_MASK;
    tile_val = raw & TILE_MASK;
    if (tile_val > CAP) begin
      tile_val = CAP;
    end
    clean    = tiled ? tile_val : lin_val;
    misalign = tiled && (|(lin_val & ~TILE_MASK));
  end
endmodule

// File: rtl/sprite_shadow_regs.sv
module sprite_shadow_regs
  import sprite_shadow_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] stride_clean,
  input  logic          stride_bad,
  input  logic          vblank,
  output logic [AW-1:0] pend_start,
  output logic [AW-1:0] pend_stride,
  output logic [AW-1:0] pend_offset,
  output logic [AW-1:0] live_start,
  output logic [AW-1:0] live_stride,
  output logic [AW-1:0] live_offset,
  output logic          armed,
  output logic          err,
  output logic          xfer
);
  logic [AW-1:0] pend_start_d, pend_stride_d, pend_offset_d;
  logic          armed_d, err_d;
  logic          wr_start, wr_stride, wr_offset, wr_status;

  always_comb begin
    wr_start  = wr_en && (wr_sel == SEL_START);
    wr_stride = wr_en && (wr_sel == SEL_STRIDE);
    wr_offset = wr_en && (wr_sel == SEL_OFFSET);
    wr_status = wr_en && (wr_sel == SEL_STATUS);
    xfer      = vblank && armed;

    pend_start_d  = wr_start  ? wr_data      : pend_start;
    pend_stride_d = wr_stride ? stride_clean : pend_stride;
    pend_offset_d = wr_offset ? wr_data      : pend_offset;

    armed_d = armed;
    if (xfer)     armed_d = 1'b0;
    if (wr_start) armed_d = 1'b1;

    err_d = err;
    if (wr_status)               err_d = 1'b0;
    if (wr_stride && stride_bad) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_start  <= '0;
      pend_stride <= '0;
      pend_offset <= '0;
      armed       <= 1'b0;
      err         <= 1'b0;
    end else begin
      pend_start  <= pend_start_d;
      pend_stride <= pend_stride_d;
      pend_offset <= pend_offset_d;
      armed       <= armed_d;
      err         <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_start  <= '0;
      live_stride <= '0;
      live_offset <= '0;
    end else if (xfer) begin
      live_start  <= pend_start;
      live_stride <= pend_stride;
      live_offset <= pend_offset;
    end
  end
endmodule

// File: rtl/sprite_line_walker.sv
module sprite_line_walker #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vblank,
  input  logic          line_strobe,
  input  logic          reverse,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] line_addr
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = vblank || line_strobe;
    if (vblank)       addr_d = base;
    else if (reverse) addr_d = line_addr - stride;
    else              addr_d = line_addr + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_addr <= '0;
    else if (addr_en) line_addr <= addr_d;
  end
endmodule

// File: rtl/sprite_addr_shadow.sv
module sprite_addr_shadow
  import sprite_shadow_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned TILE_MAX = 16384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          tiled_mode,
  input  logic          rot180,
  input  logic          vblank,
  input  logic          line_strobe,
  output logic [AW-1:0] live_start,
  output logic [AW-1:0] live_stride,
  output logic [AW-1:0] live_offset,
  output logic [AW-1:0] line_addr,
  output logic          update_armed,
  output logic          stride_err
);
  logic [AW-1:0] stride_clean;
  logic          stride_bad;
  logic [AW-1:0] pend_start, pend_stride, pend_offset;
  logic          xfer;
  logic [AW-1:0] walk_base;

  sprite_stride_filter #(
    .AW(AW), .LIN_LSB(6), .TILE_LSB(8), .TILE_MAX(TILE_MAX)
  ) u_filter (
    .raw(wr_data), .tiled(tiled_mode), .clean(stride_clean), .misalign(stride_bad)
  );

  sprite_shadow_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stride_clean(stride_clean), .stride_bad(stride_bad), .vblank(vblank),
    .pend_start(pend_start), .pend_stride(pend_stride), .pend_offset(pend_offset),
    .live_start(live_start), .live_stride(live_stride), .live_offset(live_offset),
    .armed(update_armed), .err(stride_err), .xfer(xfer)
  );

  always_comb begin
    walk_base = xfer ? (pend_start + pend_offset) : (live_start + live_offset);
  end

  sprite_line_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .line_strobe(line_strobe),
    .reverse(rot180), .base(walk_base), .stride(live_stride), .line_addr(line_addr)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_START:  rd_data = pend_start;
      SEL_STRIDE: rd_data = pend_stride;
      SEL_OFFSET: rd_data = pend_offset;
      default:    rd_data = {{(AW-2){1'b0}}, stride_err, update_armed};
    endcase
  end
endmodule

// File: rtl/sprite_addr_shadow_chk.sv
module sprite_addr_shadow_chk #(
  parameter int unsigned AW       = 32,
  parameter int unsigned TILE_MAX = 16384
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          tiled_mode,
  input logic          rot180,
  input logic          vblank,
  input logic          line_strobe,
  input logic [AW-1:0] live_start,
  input logic [AW-1:0] live_stride,
  input logic [AW-1:0] live_offset,
  input logic [AW-1:0] line_addr,
  input logic          update_armed,
  input logic [AW-1:0] pend_stride
);
  p_gran_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live_stride[5:0] == 6'd0);

  p_tile_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && tiled_mode) |=>
      (pend_stride <= AW'(TILE_MAX)) && (pend_stride[7:0] == 8'd0));

  p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && update_armed) |=>
      $stable(live_start) && $stable(live_stride) && $stable(live_offset));

  p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> update_armed);

  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && update_armed && !(wr_en && wr_sel == 2'd0)) |=> !update_armed);

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> line_addr == live_start + live_offset);

  p_step_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !vblank && !rot180) |=> line_addr == $past(line_addr) + live_stride);

  p_step_rev_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !vblank && rot180) |=> line_addr == $past(line_addr) - live_stride);
endmodule

bind sprite_addr_shadow sprite_addr_shadow_chk #(.AW(AW), .TILE_MAX(TILE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .tiled_mode(tiled_mode),
  .rot180(rot180), .vblank(vblank), .line_strobe(line_strobe),
  .live_start(live_start), .live_stride(live_stride), .live_offset(live_offset),
  .line_addr(line_addr), .update_armed(update_armed), .pend_stride(pend_stride)
);

// File: tb/sprite_addr_shadow_tb.sv
module sprite_addr_shadow_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        tiled_mode = 1'b0;
  logic        rot180 = 1'b0;
  logic        vblank = 1'b0;
  logic        line_strobe = 1'b0;
  logic [31:0] live_start, live_stride, live_offset, line_addr;
  logic        update_armed, stride_err;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sprite_addr_shadow u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tiled_mode(tiled_mode), .rot180(rot180),
    .vblank(vblank), .line_strobe(line_strobe), .live_start(live_start),
    .live_stride(live_stride), .live_offset(live_offset), .line_addr(line_addr),
    .update_armed(update_armed), .stride_err(stride_err)
  );

  typedef struct packed {
    logic        tiled;
    logic [31:0] data;
    logic [31:0] exp;
    logic        err;
  } svec_t;

  localparam int NV = 9;
  localparam svec_t VEC [NV] = '{
    '{1'b0, 32'h0000_1234, 32'h0000_1200, 1'b0},
    '{1'b0, 32'h0010_0040, 32'h0010_0040, 1'b0},
    '{1'b0, 32'h0001_0000, 32'h0001_0000, 1'b0},
    '{1'b1, 32'h0000_0800, 32'h0000_0800, 1'b0},
    '{1'b1, 32'h0000_08C0, 32'h0000_0800, 1'b1},
    '{1'b1, 32'h0001_0000, 32'h0000_4000, 1'b0},
    '{1'b1, 32'h0000_4000, 32'h0000_4000, 1'b0},
    '{1'b1, 32'h0000_003F, 32'h0000_0000, 1'b0},
    '{1'b1, 32'h0001_0040, 32'h0000_4000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [31:0] d,
                       input logic vb, input logic ls);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; vblank = vb; line_strobe = ls;
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0; line_strobe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 live_start", live_start, 32'h0);
    check("R1 live_stride", live_stride, 32'h0);
    check("R1 live_offset", live_offset, 32'h0);
    check("R1 line_addr", line_addr, 32'h0);
    check("R1 armed/err", {30'h0, stride_err, update_armed}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), v);
      check("R1 pending", v, 32'h0);
    end

    // R2 R3 R4: stride cleaning table
    for (int i = 0; i < NV; i++) begin
      tiled_mode = VEC[i].tiled;
      drive(1'b1, 2'd3, 32'h0, 1'b0, 1'b0);
      drive(1'b1, 2'd1, VEC[i].data, 1'b0, 1'b0);
      rd(2'd1, v);
      check(VEC[i].tiled ? "R4 tiled stride" : "R2 linear stride", v, VEC[i].exp);
      check("R3 stride_err", {31'h0, stride_err}, {31'h0, VEC[i].err});
    end
    // R3: error flag clears on status write
    drive(1'b1, 2'd3, 32'h0, 1'b0, 1'b0);
    check("R3 err cleared", {31'h0, stride_err}, 32'h0);
    tiled_mode = 1'b0;

    // R5: stride/offset writes do not reach live without arming
    drive(1'b1, 2'd1, 32'h0000_0200, 1'b0, 1'b0);
    drive(1'b1, 2'd2, 32'h0000_0100, 1'b0, 1'b0);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
    check("R5 live_stride", live_stride, 32'h0);
    check("R5 live_offset", live_offset, 32'h0);
    check("R5 armed", {31'h0, update_armed}, 32'h0);

    // R6 R11: start write arms, blank transfers
    drive(1'b1, 2'd0, 32'h0001_0000, 1'b0, 1'b0);
    check("R6 armed", {31'h0, update_armed}, 32'h1);
    rd(2'd3, v);
    check("R11 status", v, 32'h1);
    check("R6 live_start pre", live_start, 32'h0);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
    check("R6 live_start", live_start, 32'h0001_0000);
    check("R6 live_stride", live_stride, 32'h0000_0200);
    check("R6 live_offset", live_offset, 32'h0000_0100);
    check("R6 disarmed", {31'h0, update_armed}, 32'h0);
    check("R8 reload", line_addr, 32'h0001_0100);

    // R9 R10: line walking
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    check("R9 step1", line_addr, 32'h0001_0300);
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    check("R9 step2", line_addr, 32'h0001_0500);
    rot180 = 1'b1;
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    check("R10 reverse", line_addr, 32'h0001_0300);
    rot180 = 1'b0;

    // R7: start write coinciding with blank waits one frame
    drive(1'b1, 2'd0, 32'h0002_0000, 1'b1, 1'b0);
    check("R7 no transfer", live_start, 32'h0001_0000);
    check("R7 armed", {31'h0, update_armed}, 32'h1);
    check("R8 reload live", line_addr, 32'h0001_0100);
    drive(1'b0, 2'd0, 32'h0, 1'b1, 1'b0);
    check("R7 next blank", live_start, 32'h0002_0000);
    check("R8 reload new", line_addr, 32'h0002_0100);

    // R2: pending read-back
    rd(2'd0, v);
    check("R2 pend start", v, 32'h0002_0000);
    rd(2'd2, v);
    check("R2 pend offset", v, 32'h0000_0100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule